// File: doc/BRIEF.md
# Serial Line Code Encoder

This block turns a serial NRZ bit stream into one of four line codes: plain NRZ, NRZI, return-to-zero, or Manchester. It runs on a clock at twice the bit rate. Every bit therefore occupies two consecutive half-bit slots. A phase register, cleared by reset, alternates between the first and the second slot. The data bit and the code selection are taken only on the clock edge that opens a first slot.

The output is a single registered code bit, and it is a pure function of the stored state. A data change between sampling edges never reaches the line. The value for the first half of a bit appears right after the sampling edge. The value for the second half appears one clock later.

The code selection is stored together with each bit. The stream can therefore change from one code to another at any bit boundary without corrupting the bit already in flight. The NRZI running level advances only for bits that are sent in NRZI mode. The level is kept while other codes are in use.

Top module: `line_code_encoder`

## Requirements
- R1: While `rstN` is low, `codeOut` is 0, the phase returns to first-slot, and the NRZI running level becomes 0. The first rising edge after release is a sampling edge.
- R2: `dataIn` and `modeSel` are captured only on a sampling edge. Sampling edges are the first edge after reset and then every second edge. Values on these inputs at any other time have no effect on `codeOut`.
- R3: The first-half value of a bit is on `codeOut` after its sampling edge. The second-half value is on `codeOut` after the following edge. Before the first sampling edge after reset, `codeOut` stays 0.
- R4: With `modeSel` = 2'b00 (NRZ), both halves equal the data bit.
- R5: With `modeSel` = 2'b01 (NRZI), a 0 keeps the running level and a 1 inverts it, and both halves carry the new level. Bits sent in any other mode leave the level unchanged.
- R6: With `modeSel` = 2'b10 (RZ), a 1 gives high then low, and a 0 gives low in both halves.
- R7: With `modeSel` = 2'b11 (Manchester, default polarity), a 0 gives high then low, and a 1 gives low then high. Every bit therefore has a transition in the middle.
- R8: The code can change at every bit boundary. Each bit is coded entirely in the mode captured with that bit, whatever mode the previous bit used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Half-bit clock, twice the bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| dataIn | input | 1 | NRZ data bit, captured on sampling edges |
| modeSel | input | 2 | Line code select: 00 NRZ, 01 NRZI, 10 RZ, 11 Manchester |
| codeOut | output | 1 | Registered line-coded output |

## Verification
On a sampling edge, two things happen in the same clock. The second half of the previous bit leaves the line under the stored mode. The first half of the new bit is computed from the live mode and data. The bench draws a new random mode for almost every bit, so many boundaries join two different codes. NRZI bits are interleaved with other modes, which tests that the running level survives. In the middle of each bit, the bench also drives random values onto `dataIn` and `modeSel`. A reference encoder predicts both half-slots of every bit, and each slot is compared separately. A mode that leaks across a boundary, or a stray capture in the middle of a bit, therefore shows up as a wrong slot.

// File: rtl/line_code_pkg.sv
package line_code_pkg;

  typedef enum logic [1:0] {
    LC_NRZ   = 2'b00,
    LC_NRZI  = 2'b01,
    LC_RZ    = 2'b10,
    LC_MANCH = 2'b11
  } lineCode_e;

  // strobes from slot control to the coding datapath
  typedef struct packed {
    logic takeBit;     // the coming edge opens a first half-bit slot
    logic secondSlot;  // the coming edge opens a second half-bit slot
  } slotStb_t;

endpackage

// File: rtl/line_code_ctrl.sv
module line_code_ctrl
  import line_code_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  output slotStb_t stb
);

  logic phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= 1'b0;
    else       phase <= ~phase;
  end

  assign stb.takeBit    = ~phase;
  assign stb.secondSlot = phase;

  // R2
  take_then_second_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.takeBit |=> stb.secondSlot);

  // R2
  second_then_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.secondSlot |=> stb.takeBit);

endmodule

// File: rtl/line_code_dp.sv
module line_code_dp
  import line_code_pkg::*;
#(
  parameter bit MANCH_ONE_RISING = 1'b1
) (
  input  logic      clk,
  input  logic      rstN,
  input  slotStb_t  stb,
  input  logic      dataIn,
  input  lineCode_e modeIn,
  output logic      codeOut
);

  lineCode_e modeReg;
  logic      bitReg;
  logic      levelReg;
  logic      nextLevel;
  logic      manchLead;
  logic      manchTrail;
  logic      firstVal;
  logic      secondVal;

  generate
    if (MANCH_ONE_RISING) begin : gManchRise
      assign manchLead  = ~dataIn;
      assign manchTrail = bitReg;
    end else begin : gManchFall
      assign manchLead  = dataIn;
      assign manchTrail = ~bitReg;
    end
  endgenerate

  always_comb begin
    nextLevel = (modeIn == LC_NRZI) ? (levelReg ^ dataIn) : levelReg;
    case (modeIn)
      LC_NRZ:   firstVal = dataIn;
      LC_NRZI:  firstVal = nextLevel;
      LC_RZ:    firstVal = dataIn;
      default:  firstVal = manchLead;
    endcase
    case (modeReg)
      LC_NRZ:   secondVal = bitReg;
      LC_NRZI:  secondVal = levelReg;
      LC_RZ:    secondVal = 1'b0;
      default:  secondVal = manchTrail;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= LC_NRZ;
      bitReg   <= 1'b0;
      levelReg <= 1'b0;
      codeOut  <= 1'b0;
    end else if (stb.takeBit) begin
      modeReg  <= modeIn;
      bitReg   <= dataIn;
      levelReg <= nextLevel;
      codeOut  <= firstVal;
    end else begin
      codeOut  <= secondVal;
    end
  end

  // R4
  nrz_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeBit && modeIn == LC_NRZ) |=> (codeOut == $past(dataIn)));

  // R4
  flat_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.secondSlot && (modeReg == LC_NRZ || modeReg == LC_NRZI)) |=> $stable(codeOut));

  // R6
  rz_low_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.secondSlot && modeReg == LC_RZ) |=> !codeOut);

  // R7
  manch_mid_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.secondSlot && modeReg == LC_MANCH) |=> (codeOut != $past(codeOut)));

  // R5
  nrzi_zero_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeBit && modeIn == LC_NRZI && !dataIn) |=> (codeOut == $past(levelReg)));

endmodule

// File: rtl/line_code_encoder.sv
module line_code_encoder
  import line_code_pkg::*;
#(
  parameter bit MANCH_ONE_RISING = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dataIn,
  input  logic [1:0] modeSel,
  output logic       codeOut
);

  slotStb_t  stb;
  lineCode_e modeIn;

  assign modeIn = lineCode_e'(modeSel);

  line_code_ctrl uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .stb  (stb)
  );

  line_code_dp #(
    .MANCH_ONE_RISING (MANCH_ONE_RISING)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .dataIn  (dataIn),
    .modeIn  (modeIn),
    .codeOut (codeOut)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk) !rstN |-> !codeOut);

endmodule

// File: tb/line_code_encoder_test.sv
module line_code_encoder_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dataIn = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       codeOut;

  always #(CLK_PERIOD / 2) clk = ~clk;

  line_code_encoder uut (
    .clk     (clk),
    .rstN    (rstN),
    .dataIn  (dataIn),
    .modeSel (modeSel),
    .codeOut (codeOut)
  );

  typedef struct {
    logic  val;
    string req;
  } exp_t;

  exp_t expQ[$];
  int   checks = 0;
  int   failures = 0;
  logic refLevel = 1'b0;
  bit   done = 1'b0;

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // driver: one bit = two half-slots; junk exercises mid-bit input changes (R2)
  task automatic pushBit(input logic [1:0] m, input logic d, input bit junk);
    logic  f;
    logic  s;
    string tag;
    case (m)
      2'b00: begin f = d; s = d; tag = "R4/R8 nrz"; end
      2'b01: begin refLevel = refLevel ^ d; f = refLevel; s = refLevel; tag = "R5/R8 nrzi"; end
      2'b10: begin f = d; s = 1'b0; tag = "R6/R8 rz"; end
      default: begin f = ~d; s = d; tag = "R7/R8 manchester"; end
    endcase
    dataIn  = d;
    modeSel = m;
    expQ.push_back('{f, {tag, " first half R3"}});
    expQ.push_back('{s, {tag, " second half R2"}});
    @(negedge clk);
    if (junk) begin
      dataIn  = 1'($urandom);
      modeSel = 2'($urandom);
    end
    @(negedge clk);
  endtask

  task automatic monitor(input int n);
    repeat (n) begin
      exp_t e;
      @(negedge clk);
      if (expQ.size() == 0) begin
        check("R3 queue underflow", 1'b1, 1'b0);
      end else begin
        e = expQ.pop_front();
        check(e.req, codeOut, e.val);
      end
    end
  endtask

  task automatic runPattern(input logic [1:0] m, input logic [7:0] pat, input int n);
    fork
      begin
        for (int i = 0; i < n; i++) pushBit(m, pat[i % 8], 1'b1);
      end
      monitor(2 * n);
    join
  endtask

  task automatic runRandom(input int n);
    fork
      begin
        for (int i = 0; i < n; i++)
          pushBit(2'($urandom), 1'($urandom), 1'($urandom));
      end
      monitor(2 * n);
    join
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset output", codeOut, 1'b0);
    rstN = 1'b1;
    // R3: output still low before the first sampling edge
    #1 check("R3 before first sample", codeOut, 1'b0);
    @(negedge clk);
    check("R3 one slot after release with data 0", codeOut, 1'b0);
    @(negedge clk);
    // now the next edge is again a sampling edge
    runPattern(2'b00, 8'b0110_1001, 8);
    runPattern(2'b01, 8'b1101_0011, 8);
    runPattern(2'b10, 8'b1011_0010, 8);
    runPattern(2'b11, 8'b0100_1110, 8);
    runRandom(300);
    // make the NRZI level 1 before a mid-run reset
    if (refLevel == 1'b0) runPattern(2'b01, 8'h01, 1);
    rstN = 1'b0;
    refLevel = 1'b0;
    #1 check("R1 reset mid-stream output", codeOut, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    // R1/R5: NRZI level restarts from 0, a zero bit must give low
    fork
      pushBit(2'b01, 1'b0, 1'b0);
      monitor(2);
    join
    runRandom(200);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired R3 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule